// File: doc/BRIEF.md
# Synchronous Serial Status Flags

This block holds the status flags and data registers of a clocked synchronous serial unit. It has a transmit data register that feeds an 8-bit shift register, so one byte can wait while the previous byte shifts out. It also has a receive data register. A shift engine outside the block reports its events: a byte was taken into the shifter, one bit was shifted, the last bit was sent, a byte was received, and a transfer started or is in progress. From these events the block sets five flags: transmit-empty, transmit-end, receive-full, overrun and chip-select conflict.

Software reaches the block through a small register bus with a register select, a read strobe and a write strobe. Read data is combinational from the selected register. A flag can be cleared from the bus only by a handshake. Software first reads the status register while the flag is 1, which arms that flag. It then writes 0 to the flag's bit. An overrun blocks further reception while the receive register is still full, and it blocks transmit loads in master mode. Chip-select conflicts are detected in 4-wire mode, and the rule depends on whether the unit is master or slave.

Top module: `sync_serial_flags`

## Requirements
- R1: After reset the status register, the transmit data register, the receive data register and the shifter all read 0.
- R2: The register select encodes 0 = status, 1 = transmit data, 2 = receive data, 3 = reads 0. Status bit 0 is the conflict flag, bit 2 overrun, bit 5 receive-full, bit 6 transmit-end and bit 7 transmit-empty. Bits 1, 3 and 4 always read 0.
- R3: A status write that has a 1 in a flag's bit leaves that flag unchanged. A status write of 0 to a flag that has not been armed also leaves the flag unchanged.
- R4: A status read (read strobe with select 0) arms each flag that reads as 1. A later status write with 0 in that flag's bit clears the flag and disarms it. When the flag is set by hardware, its arm is dropped. When a hardware set and a qualifying clear fall in the same cycle, the flag stays 1.
- R5: An accepted reception with receive-full at 0 stores the byte and sets receive-full. A read strobe with select 2 clears receive-full.
- R6: An accepted reception with receive-full at 1 sets overrun and discards the byte.
- R7: While overrun and receive-full are both 1, rx_accept is 0 and receptions change nothing. While overrun is 1 in master mode, tx_allow is 0 and shifter loads are ignored.
- R8: Transmit-empty sets when an allowed load copies the transmit data register into the shifter, and also on a rising edge of tx_enable. A transmit data write clears both transmit-empty and transmit-end, and this clear wins over a set in the same cycle.
- R9: Transmit-end sets on eng_last_bit only if transmit-empty is 1 in that cycle.
- R10: In 4-wire master mode, eng_start sets the conflict flag if cs_in is low.
- R11: In 4-wire slave mode, a low-to-high edge of cs_in sets the conflict flag while eng_busy is 1.
- R12: The shifter sends its most significant bit first on tx_bit. Each eng_shift moves it one place toward the MSB and fills with 0. A load has priority over a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe (read side effects) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of selected register |
| master_mode | input | 1 | 1 = master, 0 = slave |
| four_wire | input | 1 | 1 = chip-select is used |
| tx_enable | input | 1 | Transmit enable level |
| cs_in | input | 1 | Chip-select input (active low) |
| eng_start | input | 1 | Transfer start pulse |
| eng_busy | input | 1 | Transfer in progress |
| eng_load | input | 1 | Shifter takes transmit byte |
| eng_shift | input | 1 | Shift one bit |
| eng_last_bit | input | 1 | Last bit of byte sent |
| eng_rx_done | input | 1 | Byte received |
| eng_rx_byte | input | DW | Received byte |
| tx_bit | output | 1 | Current serial output bit |
| tx_allow | output | 1 | Transmission may proceed |
| rx_accept | output | 1 | Reception may proceed |

## Verification
The bench checks the handshake from several directions. It writes 0 with no prior read, writes 1 after arming, and lets a hardware set meet a clear in the same cycle. A design that clears on any write of 0 fails the first case, and one that keeps the arm after a re-set fails the third. It also drives a reception into a full receive register and then keeps receiving under overrun. A design that overwrites the byte or never locks out would show a changed receive register. Transmit-end is triggered both with transmit-empty at 1 and at 0, and chip-select edges are driven with eng_busy on and off, which exposes flags that set regardless of the qualifier.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  localparam int STAT_W = 8;
  localparam int NFLAG  = 5;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_TXD  = 2'd1,
    SEL_RXD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // flag indices inside the block
  localparam int F_CONF = 0;
  localparam int F_OVR  = 1;
  localparam int F_RXF  = 2;
  localparam int F_TEND = 3;
  localparam int F_TXE  = 4;

  // bit position of each flag in the status byte
  function automatic int flag_pos(input int idx);
    case (idx)
      F_CONF:  return 0;
      F_OVR:   return 2;
      F_RXF:   return 5;
      F_TEND:  return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic hw_clr,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic wr_bit,
  output logic flag
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic sw_clr, en;

  always_comb begin
    sw_clr = stat_wr && !wr_bit && arm_q;
    flag_d = flag_q;
    arm_d  = arm_q;
    if (set_ev) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (hw_clr || sw_clr) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (stat_rd && flag_q) begin
      arm_d  = 1'b1;
    end
    en = set_ev || hw_clr || sw_clr || stat_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/ssf_tx_path.sv
module ssf_tx_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tdr_wr,
  input  logic [DW-1:0] wdata,
  input  logic          load,
  input  logic          shift,
  output logic [DW-1:0] tdr,
  output logic [DW-1:0] shreg,
  output logic          tx_bit
);
  logic [DW-1:0] tdr_q, tdr_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          sh_en;

  always_comb begin
    tdr_d = tdr_wr ? wdata : tdr_q;
    sh_d  = sh_q;
    if (load)       sh_d = tdr_q;
    else if (shift) sh_d = {sh_q[DW-2:0], 1'b0};
    sh_en = load || shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr_q <= '0;
      sh_q  <= '0;
    end else begin
      if (tdr_wr) tdr_q <= tdr_d;
      if (sh_en)  sh_q  <= sh_d;
    end
  end

  assign tdr    = tdr_q;
  assign shreg  = sh_q;
  assign tx_bit = sh_q[DW-1];
endmodule

// File: rtl/ssf_rx_path.sv
module ssf_rx_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] rdr
);
  logic [DW-1:0] rdr_q, rdr_d;

  always_comb rdr_d = store ? rx_byte : rdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdr_q <= '0;
    else if (store) rdr_q <= rdr_d;
  end

  assign rdr = rdr_q;
endmodule

// File: rtl/ssf_evt_detect.sv
module ssf_evt_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_in,
  input  logic tx_enable,
  input  logic four_wire,
  input  logic master_mode,
  input  logic eng_start,
  input  logic eng_busy,
  output logic conf_ev,
  output logic txen_rise
);
  logic cs_q, ten_q;
  logic cs_rise, mst_conf, slv_conf;

  always_comb begin
    cs_rise   = cs_in && !cs_q;
    mst_conf  = four_wire && master_mode && eng_start && !cs_in;
    slv_conf  = four_wire && !master_mode && eng_busy && cs_rise;
    conf_ev   = mst_conf || slv_conf;
    txen_rise = tx_enable && !ten_q;
  end

  // chip select idles high (deselected)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      ten_q <= 1'b0;
    end else begin
      cs_q  <= cs_in;
      ten_q <= tx_enable;
    end
  end
endmodule

// File: rtl/sync_serial_flags.sv
module sync_serial_flags
  import ssf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          master_mode,
  input  logic          four_wire,
  input  logic          tx_enable,
  input  logic          cs_in,
  input  logic          eng_start,
  input  logic          eng_busy,
  input  logic          eng_load,
  input  logic          eng_shift,
  input  logic          eng_last_bit,
  input  logic          eng_rx_done,
  input  logic [DW-1:0] eng_rx_byte,
  output logic          tx_bit,
  output logic          tx_allow,
  output logic          rx_accept
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic stat_rd, stat_wr, txd_wr, rxd_rd;
  logic conf_ev, txen_rise;
  logic load_ok, rx_store, ovr_ev;
  logic [NFLAG-1:0] flag_f, set_f, clr_f;
  logic [STAT_W-1:0] status_w;
  logic [DW-1:0] tdr_q, rdr_q, sh_q;

  always_comb begin
    stat_rd = reg_rd && (reg_sel == SEL_STAT);
    stat_wr = reg_wr && (reg_sel == SEL_STAT);
    txd_wr  = reg_wr && (reg_sel == SEL_TXD);
    rxd_rd  = reg_rd && (reg_sel == SEL_RXD);
  end

  always_comb begin
    rx_accept = !(flag_f[F_OVR] && flag_f[F_RXF]);
    tx_allow  = !(flag_f[F_OVR] && master_mode);
    load_ok   = eng_load && tx_allow;
    rx_store  = eng_rx_done && rx_accept && !flag_f[F_RXF];
    ovr_ev    = eng_rx_done && rx_accept && flag_f[F_RXF];

    set_f         = '0;
    clr_f         = '0;
    set_f[F_CONF] = conf_ev;
    set_f[F_OVR]  = ovr_ev;
    set_f[F_RXF]  = rx_store;
    clr_f[F_RXF]  = rxd_rd;
    set_f[F_TXE]  = (load_ok || txen_rise) && !txd_wr;
    clr_f[F_TXE]  = txd_wr;
    set_f[F_TEND] = eng_last_bit && flag_f[F_TXE] && !txd_wr;
    clr_f[F_TEND] = txd_wr;
  end

  ssf_evt_detect u_evt (
    .clk         (clk),
    .rst_n       (rst_s),
    .cs_in       (cs_in),
    .tx_enable   (tx_enable),
    .four_wire   (four_wire),
    .master_mode (master_mode),
    .eng_start   (eng_start),
    .eng_busy    (eng_busy),
    .conf_ev     (conf_ev),
    .txen_rise   (txen_rise)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    localparam int POS = flag_pos(g);
    ssf_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_s),
      .set_ev  (set_f[g]),
      .hw_clr  (clr_f[g]),
      .stat_rd (stat_rd),
      .stat_wr (stat_wr),
      .wr_bit  (reg_wdata[POS]),
      .flag    (flag_f[g])
    );
  end

  always_comb begin
    status_w = '0;
    for (int i = 0; i < NFLAG; i++) status_w[flag_pos(i)] = flag_f[i];
  end

  ssf_tx_path #(.DW(DW)) u_tx (
    .clk    (clk),
    .rst_n  (rst_s),
    .tdr_wr (txd_wr),
    .wdata  (reg_wdata),
    .load   (load_ok),
    .shift  (eng_shift),
    .tdr    (tdr_q),
    .shreg  (sh_q),
    .tx_bit (tx_bit)
  );

  ssf_rx_path #(.DW(DW)) u_rx (
    .clk     (clk),
    .rst_n   (rst_s),
    .store   (rx_store),
    .rx_byte (eng_rx_byte),
    .rdr     (rdr_q)
  );

  always_comb begin
    case (reg_sel)
      SEL_STAT: reg_rdata = DW'(status_w);
      SEL_TXD:  reg_rdata = tdr_q;
      SEL_RXD:  reg_rdata = rdr_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ssf_checker.sv
module ssf_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    stat,
  input logic          stat_wr,
  input logic          txd_wr,
  input logic [DW-1:0] wdata,
  input logic          master_mode,
  input logic          eng_load,
  input logic          eng_shift,
  input logic          eng_last_bit,
  input logic          eng_rx_done,
  input logic [DW-1:0] rdr,
  input logic [DW-1:0] shreg
);
  localparam logic [7:0] FMASK = 8'b1110_0101;

  p_write1_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && ((wdata[7:0] & FMASK) == FMASK)) |=> (($past(stat) & ~stat & FMASK) == 8'h00));

  p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[2]) |-> ($past(eng_rx_done) && $past(stat[5])));

  p_rx_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_done && stat[2] && stat[5]) |=> $stable(rdr));

  p_tx_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_load && !eng_shift && stat[2] && master_mode) |=> $stable(shreg));

  p_txwr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txd_wr |=> (!stat[7] && !stat[6]));

  p_tend_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[6]) |-> ($past(eng_last_bit) && $past(stat[7])));
endmodule

bind sync_serial_flags ssf_checker #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_s),
  .stat         (status_w),
  .stat_wr      (stat_wr),
  .txd_wr       (txd_wr),
  .wdata        (reg_wdata),
  .master_mode  (master_mode),
  .eng_load     (eng_load),
  .eng_shift    (eng_shift),
  .eng_last_bit (eng_last_bit),
  .eng_rx_done  (eng_rx_done),
  .rdr          (rdr_q),
  .shreg        (sh_q)
);

// File: tb/sync_serial_flags_tb.sv
module sync_serial_flags_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] FMASK = 8'b1110_0101;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_sel;
  logic       reg_rd, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       master_mode, four_wire, tx_enable, cs_in;
  logic       eng_start, eng_busy, eng_load, eng_shift, eng_last_bit, eng_rx_done;
  logic [7:0] eng_rx_byte;
  logic       tx_bit, tx_allow, rx_accept;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_stat, m_arm, m_tdr, m_rdr, m_sh;
  logic       m_cs_q, m_ten_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_flags #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .master_mode(master_mode),
    .four_wire(four_wire), .tx_enable(tx_enable), .cs_in(cs_in), .eng_start(eng_start),
    .eng_busy(eng_busy), .eng_load(eng_load), .eng_shift(eng_shift),
    .eng_last_bit(eng_last_bit), .eng_rx_done(eng_rx_done), .eng_rx_byte(eng_rx_byte),
    .tx_bit(tx_bit), .tx_allow(tx_allow), .rx_accept(rx_accept)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(input logic [1:0] sel);
    case (sel)
      2'd0:    return m_stat;
      2'd1:    return m_tdr;
      2'd2:    return m_rdr;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_rx_accept();
    return !(m_stat[2] && m_stat[5]);
  endfunction

  function automatic logic exp_tx_allow();
    return !(m_stat[2] && master_mode);
  endfunction

  task automatic model_reset();
    m_stat = 8'h00; m_arm = 8'h00; m_tdr = 8'h00; m_rdr = 8'h00; m_sh = 8'h00;
    m_cs_q = 1'b1; m_ten_q = 1'b0;
  endtask

  task automatic model_update();
    logic [7:0] setv, clrv;
    logic stat_rd, stat_wr, txd_wr, rxd_rd, rx_acc, tx_ok, cs_rise, ten_rise, sw;
    logic [7:0] tdr_old;
    stat_rd  = reg_rd && reg_sel == 2'd0;
    stat_wr  = reg_wr && reg_sel == 2'd0;
    txd_wr   = reg_wr && reg_sel == 2'd1;
    rxd_rd   = reg_rd && reg_sel == 2'd2;
    rx_acc   = exp_rx_accept();
    tx_ok    = exp_tx_allow();
    cs_rise  = cs_in && !m_cs_q;
    ten_rise = tx_enable && !m_ten_q;
    tdr_old  = m_tdr;
    setv = 8'h00; clrv = 8'h00;
    setv[0] = (eng_start && four_wire && master_mode && !cs_in) ||
              (four_wire && !master_mode && eng_busy && cs_rise);
    setv[2] = eng_rx_done && rx_acc && m_stat[5];
    setv[5] = eng_rx_done && rx_acc && !m_stat[5];
    clrv[5] = rxd_rd;
    setv[7] = ((eng_load && tx_ok) || ten_rise) && !txd_wr;
    clrv[7] = txd_wr;
    setv[6] = eng_last_bit && m_stat[7] && !txd_wr;
    clrv[6] = txd_wr;
    for (int k = 0; k < 8; k++) begin
      if (FMASK[k]) begin
        sw = stat_wr && !reg_wdata[k] && m_arm[k];
        if (setv[k])             begin m_stat[k] = 1'b1; m_arm[k] = 1'b0; end
        else if (clrv[k] || sw)  begin m_stat[k] = 1'b0; m_arm[k] = 1'b0; end
        else if (stat_rd && m_stat[k]) m_arm[k] = 1'b1;
      end
    end
    if (setv[5]) m_rdr = eng_rx_byte;
    if (txd_wr)  m_tdr = reg_wdata;
    if (eng_load && tx_ok) m_sh = tdr_old;
    else if (eng_shift)    m_sh = {m_sh[6:0], 1'b0};
    m_cs_q  = cs_in;
    m_ten_q = tx_enable;
  endtask

  // one clock: check combinational outputs, clock, update model, drop pulses
  task automatic step();
    #1;
    case (reg_sel)
      2'd0:    chk("R4 status vs model", reg_rdata, exp_rdata(reg_sel));
      2'd1:    chk("R8 tx data vs model", reg_rdata, exp_rdata(reg_sel));
      2'd2:    chk("R5 rx data vs model", reg_rdata, exp_rdata(reg_sel));
      default: chk("R2 unused select", reg_rdata, 8'h00);
    endcase
    chk("R12 tx_bit", {7'd0, tx_bit}, {7'd0, m_sh[7]});
    chk("R7 rx_accept", {7'd0, rx_accept}, {7'd0, exp_rx_accept()});
    chk("R7 tx_allow", {7'd0, tx_allow}, {7'd0, exp_tx_allow()});
    @(posedge clk);
    model_update();
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; eng_start = 0; eng_load = 0; eng_shift = 0;
    eng_last_bit = 0; eng_rx_done = 0;
  endtask

  task automatic peek(input logic [1:0] sel, input string tag, input logic [7:0] exp);
    reg_sel = sel;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic bus(input logic [1:0] sel, input logic rd, input logic wr, input logic [7:0] d);
    reg_sel = sel; reg_rd = rd; reg_wr = wr; reg_wdata = d;
    step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    rst_n = 0; reg_sel = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    master_mode = 0; four_wire = 0; tx_enable = 0; cs_in = 1;
    eng_start = 0; eng_busy = 0; eng_load = 0; eng_shift = 0; eng_last_bit = 0;
    eng_rx_done = 0; eng_rx_byte = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(2'd0, "R1 status after reset", 8'h00);
    peek(2'd1, "R1 tx data after reset", 8'h00);
    peek(2'd2, "R1 rx data after reset", 8'h00);
    chk("R1 shifter after reset", {7'd0, tx_bit}, 8'h00);

    // R10 master conflict
    four_wire = 1; master_mode = 1; cs_in = 0; eng_start = 1; bus(2'd0, 0, 0, 8'h00);
    cs_in = 1;
    peek(2'd0, "R10 conflict on start with cs low", 8'h01);
    eng_start = 1; bus(2'd3, 0, 0, 8'h00);
    peek(2'd0, "R10 no conflict with cs high", 8'h01);

    // R3 / R4 handshake
    bus(2'd0, 0, 1, 8'h00);
    peek(2'd0, "R3 write 0 without arm ignored", 8'h01);
    bus(2'd0, 1, 0, 8'h00);
    bus(2'd0, 0, 1, 8'hFF);
    peek(2'd0, "R3 write 1 ignored", 8'h01);
    bus(2'd0, 0, 1, 8'h00);
    peek(2'd0, "R4 read-1 then write-0 clears", 8'h00);

    // R4 set wins, arm dropped by set
    cs_in = 0; eng_start = 1; bus(2'd3, 0, 0, 8'h00);
    bus(2'd0, 1, 0, 8'h00);
    eng_start = 1; bus(2'd0, 0, 1, 8'h00);
    cs_in = 1;
    peek(2'd0, "R4 set beats clear", 8'h01);
    bus(2'd0, 0, 1, 8'h00);
    peek(2'd0, "R4 arm dropped by set", 8'h01);
    bus(2'd0, 1, 0, 8'h00);
    bus(2'd0, 0, 1, 8'h00);
    peek(2'd0, "R4 cleared after re-arm", 8'h00);

    // R5 reception
    master_mode = 0; four_wire = 0;
    eng_rx_done = 1; eng_rx_byte = 8'hA5; bus(2'd3, 0, 0, 8'h00);
    peek(2'd0, "R5 receive-full set", 8'h20);
    peek(2'd2, "R5 byte stored", 8'hA5);
    bus(2'd2, 1, 0, 8'h00);
    peek(2'd0, "R5 rx read clears receive-full", 8'h00);

    // R6 overrun
    eng_rx_done = 1; eng_rx_byte = 8'hA5; bus(2'd3, 0, 0, 8'h00);
    eng_rx_done = 1; eng_rx_byte = 8'h3C; bus(2'd3, 0, 0, 8'h00);
    peek(2'd0, "R6 overrun set", 8'h24);
    peek(2'd2, "R6 byte discarded", 8'hA5);

    // R7 lockouts
    eng_rx_done = 1; eng_rx_byte = 8'h77; bus(2'd3, 0, 0, 8'h00);
    peek(2'd2, "R7 reception ignored", 8'hA5);
    chk("R7 rx_accept low", {7'd0, rx_accept}, 8'h00);
    master_mode = 1;
    #1 chk("R7 tx_allow low", {7'd0, tx_allow}, 8'h00);
    bus(2'd1, 0, 1, 8'h81);
    eng_load = 1; bus(2'd3, 0, 0, 8'h00);
    peek(2'd0, "R7 load ignored, empty stays 0", 8'h24);
    chk("R7 shifter unchanged", {7'd0, tx_bit}, 8'h00);
    bus(2'd0, 1, 0, 8'h00);
    bus(2'd0, 0, 1, 8'hFB);
    peek(2'd0, "R4 overrun cleared alone", 8'h20);

    // R8 / R12 transmit
    eng_load = 1; bus(2'd3, 0, 0, 8'h00);
    peek(2'd0, "R8 load sets empty", 8'hA0);
    chk("R12 msb first", {7'd0, tx_bit}, 8'h01);
    eng_shift = 1; bus(2'd3, 0, 0, 8'h00);
    chk("R12 after one shift", {7'd0, tx_bit}, 8'h00);
    for (int i = 0; i < 6; i++) begin eng_shift = 1; bus(2'd3, 0, 0, 8'h00); end
    chk("R12 after seven shifts", {7'd0, tx_bit}, 8'h01);

    // R9 transmit end
    eng_last_bit = 1; bus(2'd3, 0, 0, 8'h00);
    peek(2'd0, "R9 end set with empty", 8'hE0);
    bus(2'd1, 0, 1, 8'h55);
    peek(2'd0, "R8 tx write clears empty and end", 8'h20);
    eng_last_bit = 1; bus(2'd3, 0, 0, 8'h00);
    peek(2'd0, "R9 no end when not empty", 8'h20);
    eng_load = 1; bus(2'd1, 0, 1, 8'h66);
    peek(2'd0, "R8 write wins over load", 8'h20);

    tx_enable = 1; bus(2'd3, 0, 0, 8'h00);
    peek(2'd0, "R8 enable rise sets empty", 8'hA0);

    // R11 slave conflict
    master_mode = 0; four_wire = 1; cs_in = 0; bus(2'd3, 0, 0, 8'h00);
    cs_in = 1; bus(2'd3, 0, 0, 8'h00);
    peek(2'd0, "R11 rise without busy ignored", 8'hA0);
    cs_in = 0; bus(2'd3, 0, 0, 8'h00);
    eng_busy = 1; cs_in = 1; bus(2'd3, 0, 0, 8'h00);
    eng_busy = 0;
    peek(2'd0, "R11 rise during transfer", 8'hA1);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      reg_sel   = 2'($urandom_range(0, 3));
      reg_rd    = (r < 45);
      reg_wr    = (r >= 45 && r < 70);
      reg_wdata = ($urandom_range(0, 1) == 1) ? 8'h00 : 8'($urandom);
      if ($urandom_range(0, 49) == 0) master_mode = ~master_mode;
      if ($urandom_range(0, 99) == 0) four_wire = ~four_wire;
      if ($urandom_range(0, 39) == 0) tx_enable = ~tx_enable;
      if ($urandom_range(0, 5) == 0)  cs_in = ~cs_in;
      if ($urandom_range(0, 9) == 0)  eng_busy = ~eng_busy;
      eng_start    = ($urandom_range(0, 19) == 0);
      eng_load     = ($urandom_range(0, 7) == 0);
      eng_shift    = ($urandom_range(0, 2) == 0);
      eng_last_bit = ($urandom_range(0, 9) == 0);
      eng_rx_done  = ($urandom_range(0, 7) == 0);
      eng_rx_byte  = 8'($urandom);
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule